// File: doc/BRIEF.md
# Dual-Port Control Register Loader

This block holds the run-time settings of a broadcast data decoder in a small bank of five registers. The settings arrive over one of two ports. The first is a three-wire synchronous serial port with a clock, an enable and a data line. The second is a parallel port with a 3-bit register select, an 8-bit data bus and an active-low store strobe. A mode pin picks which port is live. The other port is ignored while it is not selected.

Both ports deliver a register select and an 8-bit value to one shared register bank. The bank applies a per-register acceptance rule. It then presents the settings to the rest of the decoder as decoded fields: error allowances, block and frame protection counts (stored minus one), a correction threshold, and a readout block number for skipping ahead.

All port pins are sampled on the system clock. Edges of the serial clock, the serial enable and the store strobe are found by comparing each pin with its value sampled one cycle earlier.

Top module: `crl_loader`

## Requirements
- R1: After reset the decoded outputs are: error allowance back 2 and forward 2; block protection back 2 and forward 8; frame protection back 2 and forward 8; threshold 15; readout block number 0.
- R2: A serial write starts with 8 address bits sent while the enable is low, one per serial clock rising edge. In send order the bits are 0,1,0,1,1,1,1,1. The enable then goes high and exactly 16 data bits follow, least significant bit first. Bits 11..8 of the data word select the register, bits 7..0 are the value and bits 15..12 are ignored. The write takes effect when the enable falls.
- R3: A serial transfer changes no register if its address differs from the write address or if its data phase does not hold exactly 16 bits. The read address is the write address with its first-sent bit set to 1. During the data phase of a read-address transfer, `ser_rd_sel` is high, and it is low at all other times.
- R4: In parallel mode the select and data are captured at the rising edge of `par_stb_n`, using the values present while it was low. `par_dat_in` is high exactly while `par_stb_n` is low in parallel mode.
- R5: When `mode_serial` is 1 only the serial port writes. When it is 0 only the parallel port writes.
- R6: Register 0 holds the error allowances: bits 7..4 are the back value and bits 3..0 the forward value, each passed out unchanged.
- R7: Register 1 (block) and register 2 (frame) hold protection codes: bits 7..4 are back and bits 3..0 are forward. Each decoded count is its code plus 1. A nibble written as 0 leaves that nibble's previous code in place, and the other nibble still updates.
- R8: Register 3 keeps only bits 2..0 of the written value, and the decoded threshold is 8 plus that value (7 gives 15, 1 gives 9).
- R9: Register 4 takes values 0 to 189. A value above 189 leaves it unchanged.
- R10: A write whose select is 5 or above, from either port, changes no register.
- R11: A strobe or serial clock that was low while reset was held and rises before the first clock edge after release does not count as an edge. Edges are recognised from the second clock edge after release onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_serial | input | 1 | 1 selects the serial port, 0 the parallel port |
| ser_clk | input | 1 | Serial clock, data taken on its rising edge |
| ser_en | input | 1 | Serial enable: low for address, high for data |
| ser_din | input | 1 | Serial data in |
| par_sel | input | 3 | Parallel register select |
| par_data | input | 8 | Parallel data bus |
| par_stb_n | input | 1 | Active-low store strobe, capture on its rising edge |
| par_dat_in | output | 1 | High while the parallel data bus must be an input |
| ser_rd_sel | output | 1 | High during the data phase of a read-address transfer |
| err_back | output | 4 | Allowed back errors |
| err_fwd | output | 4 | Allowed forward errors |
| blk_prot_back | output | 5 | Block back protection count |
| blk_prot_fwd | output | 5 | Block forward protection count |
| frm_prot_back | output | 5 | Frame back protection count |
| frm_prot_fwd | output | 5 | Frame forward protection count |
| corr_thresh | output | 4 | Effective correction threshold |
| skip_block | output | 8 | Readout block number |

## Verification
Every port edge is first sampled by one register. The front end registers the resulting write request at the clock edge that sees the pin edge, and the bank takes the request at the following edge. A decoded output therefore changes on the second rising clock edge after the sampled strobe rise or enable fall. `ser_rd_sel` changes one edge after the sampled enable rise. The bench drives all pins on falling clock edges and waits three falling edges after each strobe or enable release before it samples, so every result is settled and no check reads a value mid-update. It sweeps all 256 values into every register through the parallel port. It also walks serial transfers with good and bad addresses, short and long bit counts, and wrong modes.

// File: rtl/crl_pkg.sv
package crl_pkg;

    localparam int REG_W      = 8;
    localparam int NIB_W      = 4;
    localparam int SEL_W      = 4;
    localparam int NREG       = 5;
    localparam int PAR_SEL_W  = 3;
    localparam int SER_ADDR_W = 8;
    localparam int SER_DATA_W = 16;
    localparam int THR_W      = 3;
    localparam int CNT_W      = NIB_W + 1;

    // Address as shifted in LSB-first: first bit sent lands in bit 0.
    localparam logic [SER_ADDR_W-1:0] SER_WR_ADDR = 8'hFA;
    localparam logic [SER_ADDR_W-1:0] SER_RD_ADDR = 8'hFB;

    localparam logic [REG_W-1:0] BLK_MAX  = 8'd189;
    localparam int               THR_BASE = 8;

    localparam logic [SEL_W-1:0] SEL_ALLOW  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_BLKP   = 4'd1;
    localparam logic [SEL_W-1:0] SEL_FRMP   = 4'd2;
    localparam logic [SEL_W-1:0] SEL_THR    = 4'd3;
    localparam logic [SEL_W-1:0] SEL_BLKNUM = 4'd4;

    localparam logic [REG_W-1:0] DEF_ALLOW  = 8'h22;
    localparam logic [REG_W-1:0] DEF_BLKP   = 8'h17;
    localparam logic [REG_W-1:0] DEF_FRMP   = 8'h17;
    localparam logic [THR_W-1:0] DEF_THR    = 3'd7;
    localparam logic [REG_W-1:0] DEF_BLKNUM = 8'd0;

    typedef struct packed {
        logic             vld;
        logic [SEL_W-1:0] sel;
        logic [REG_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic [REG_W-1:0] allow;
        logic [REG_W-1:0] blk_prot;
        logic [REG_W-1:0] frm_prot;
        logic [THR_W-1:0] thr;
        logic [REG_W-1:0] blk_num;
    } ctrl_regs_t;

endpackage

// File: rtl/crl_serial_rx.sv
module crl_serial_rx
    import crl_pkg::*;
#(
    parameter int ADDR_W = SER_ADDR_W,
    parameter int DATA_W = SER_DATA_W
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enable,
    input  logic    ser_clk,
    input  logic    ser_en,
    input  logic    ser_din,
    output wr_req_t wr_req,
    output logic    rd_sel
);

    localparam int ACNT_W = $clog2(ADDR_W + 1);
    localparam int DCNT_W = $clog2(DATA_W + 2);
    localparam logic [ACNT_W-1:0] ACNT_FULL = ACNT_W'(ADDR_W);
    localparam logic [DCNT_W-1:0] DCNT_FULL = DCNT_W'(DATA_W);
    localparam logic [DCNT_W-1:0] DCNT_OVER = DCNT_W'(DATA_W + 1);

    typedef struct packed {
        logic              clk_s;
        logic              en_s;
        logic [ADDR_W-1:0] addr_sr;
        logic [ACNT_W-1:0] addr_cnt;
        logic [DATA_W-1:0] data_sr;
        logic [DCNT_W-1:0] data_cnt;
        logic              is_wr;
        logic              is_rd;
        wr_req_t           wr;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic clk_rise, en_rise, en_fall;

    always_comb begin
        st_d       = st_q;
        st_d.clk_s = ser_clk;
        st_d.en_s  = ser_en;
        st_d.wr    = '0;
        clk_rise   = ser_clk & ~st_q.clk_s;
        en_rise    = ser_en & ~st_q.en_s;
        en_fall    = ~ser_en & st_q.en_s;
        if (!enable) begin
            st_d.addr_cnt = '0;
            st_d.data_cnt = '0;
            st_d.is_wr    = 1'b0;
            st_d.is_rd    = 1'b0;
        end else if (en_rise) begin
            st_d.is_wr    = (st_q.addr_cnt == ACNT_FULL) && (st_q.addr_sr == SER_WR_ADDR);
            st_d.is_rd    = (st_q.addr_cnt == ACNT_FULL) && (st_q.addr_sr == SER_RD_ADDR);
            st_d.data_cnt = '0;
        end else if (en_fall) begin
            if (st_q.is_wr && st_q.data_cnt == DCNT_FULL) begin
                st_d.wr.vld  = 1'b1;
                st_d.wr.sel  = st_q.data_sr[2*REG_W-5 -: SEL_W];
                st_d.wr.data = st_q.data_sr[REG_W-1:0];
            end
            st_d.is_wr    = 1'b0;
            st_d.is_rd    = 1'b0;
            st_d.addr_cnt = '0;
            st_d.data_cnt = '0;
        end else if (clk_rise) begin
            if (st_q.en_s) begin
                st_d.data_sr = {ser_din, st_q.data_sr[DATA_W-1:1]};
                if (st_q.data_cnt != DCNT_OVER) begin
                    st_d.data_cnt = st_q.data_cnt + 1'b1;
                end
            end else begin
                st_d.addr_sr = {ser_din, st_q.addr_sr[ADDR_W-1:1]};
                if (st_q.addr_cnt != ACNT_FULL) begin
                    st_d.addr_cnt = st_q.addr_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.clk_s <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_req = st_q.wr;
    assign rd_sel = st_q.is_rd;

    // R5: a serial write request only follows a cycle in serial mode
    a_r5_ser_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr.vld |-> $past(enable));

    // R2: a commit only follows an enable fall with exactly 16 data bits
    a_r2_commit_len: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr.vld |-> ($past(st_q.data_cnt) == DCNT_FULL) && $past(st_q.en_s));

endmodule

// File: rtl/crl_parallel_rx.sv
module crl_parallel_rx
    import crl_pkg::*;
#(
    parameter int SELW = PAR_SEL_W,
    parameter int DW   = REG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [SELW-1:0] par_sel,
    input  logic [DW-1:0]   par_data,
    input  logic            par_stb_n,
    output wr_req_t         wr_req,
    output logic            dat_in
);

    typedef struct packed {
        logic            stb_s;
        logic [SELW-1:0] sel_s;
        logic [DW-1:0]   data_s;
        wr_req_t         wr;
    } par_st_t;

    par_st_t st_d, st_q;
    logic stb_rise;

    always_comb begin
        st_d       = st_q;
        st_d.stb_s = par_stb_n;
        st_d.wr    = '0;
        stb_rise   = par_stb_n & ~st_q.stb_s;
        if (!par_stb_n) begin
            st_d.sel_s  = par_sel;
            st_d.data_s = par_data;
        end
        if (enable && stb_rise) begin
            st_d.wr.vld  = 1'b1;
            st_d.wr.sel  = SEL_W'(st_q.sel_s);
            st_d.wr.data = st_q.data_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.stb_s <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_req = st_q.wr;
    assign dat_in = enable & ~par_stb_n;

    // R5: a parallel write request only follows a cycle in parallel mode
    a_r5_par_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr.vld |-> $past(enable));

    // R4: a request follows a cycle in which the strobe was sampled low
    a_r4_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr.vld |-> $past(par_stb_n) && !$past(st_q.stb_s));

endmodule

// File: rtl/crl_reg_bank.sv
module crl_reg_bank
    import crl_pkg::*;
#(
    parameter int NUM_REGS = NREG
) (
    input  logic       clk,
    input  logic       rst_n,
    input  wr_req_t    wr_req,
    output ctrl_regs_t regs
);

    localparam int NNIB = REG_W / NIB_W;

    ctrl_regs_t rf_d, rf_q;
    logic [REG_W-1:0] blk_merge, frm_merge;
    logic sel_in_range;

    // Per-nibble merge: a zero code keeps the stored nibble.
    for (genvar g = 0; g < NNIB; g++) begin : g_nib
        assign blk_merge[g*NIB_W +: NIB_W] = (wr_req.data[g*NIB_W +: NIB_W] == '0)
            ? rf_q.blk_prot[g*NIB_W +: NIB_W] : wr_req.data[g*NIB_W +: NIB_W];
        assign frm_merge[g*NIB_W +: NIB_W] = (wr_req.data[g*NIB_W +: NIB_W] == '0)
            ? rf_q.frm_prot[g*NIB_W +: NIB_W] : wr_req.data[g*NIB_W +: NIB_W];
    end

    assign sel_in_range = (32'(wr_req.sel) < NUM_REGS);

    always_comb begin
        rf_d = rf_q;
        if (wr_req.vld && sel_in_range) begin
            case (wr_req.sel)
                SEL_ALLOW:  rf_d.allow    = wr_req.data;
                SEL_BLKP:   rf_d.blk_prot = blk_merge;
                SEL_FRMP:   rf_d.frm_prot = frm_merge;
                SEL_THR:    rf_d.thr      = wr_req.data[THR_W-1:0];
                SEL_BLKNUM: begin
                    if (wr_req.data <= BLK_MAX) begin
                        rf_d.blk_num = wr_req.data;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.allow    <= DEF_ALLOW;
            rf_q.blk_prot <= DEF_BLKP;
            rf_q.frm_prot <= DEF_FRMP;
            rf_q.thr      <= DEF_THR;
            rf_q.blk_num  <= DEF_BLKNUM;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign regs = rf_q;

    // R7: stored protection codes never hold a zero nibble
    a_r7_prot_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_q.blk_prot[3:0] != '0) && (rf_q.blk_prot[7:4] != '0) &&
        (rf_q.frm_prot[3:0] != '0) && (rf_q.frm_prot[7:4] != '0));

    // R9: readout block number stays in range
    a_r9_blk_range: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q.blk_num <= BLK_MAX);

    // R10: without an in-range request the bank holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req.vld && sel_in_range) |=> $stable(rf_q));

endmodule

// File: rtl/crl_loader.sv
module crl_loader
    import crl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_serial,
    input  logic                 ser_clk,
    input  logic                 ser_en,
    input  logic                 ser_din,
    input  logic [PAR_SEL_W-1:0] par_sel,
    input  logic [REG_W-1:0]     par_data,
    input  logic                 par_stb_n,
    output logic                 par_dat_in,
    output logic                 ser_rd_sel,
    output logic [NIB_W-1:0]     err_back,
    output logic [NIB_W-1:0]     err_fwd,
    output logic [CNT_W-1:0]     blk_prot_back,
    output logic [CNT_W-1:0]     blk_prot_fwd,
    output logic [CNT_W-1:0]     frm_prot_back,
    output logic [CNT_W-1:0]     frm_prot_fwd,
    output logic [NIB_W-1:0]     corr_thresh,
    output logic [REG_W-1:0]     skip_block
);

    wr_req_t    ser_wr, par_wr, bank_wr;
    ctrl_regs_t regs;

    crl_serial_rx #(.ADDR_W(SER_ADDR_W), .DATA_W(SER_DATA_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (mode_serial),
        .ser_clk (ser_clk),
        .ser_en  (ser_en),
        .ser_din (ser_din),
        .wr_req  (ser_wr),
        .rd_sel  (ser_rd_sel)
    );

    crl_parallel_rx #(.SELW(PAR_SEL_W), .DW(REG_W)) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (~mode_serial),
        .par_sel   (par_sel),
        .par_data  (par_data),
        .par_stb_n (par_stb_n),
        .wr_req    (par_wr),
        .dat_in    (par_dat_in)
    );

    always_comb begin
        bank_wr = ser_wr.vld ? ser_wr : par_wr;
    end

    crl_reg_bank #(.NUM_REGS(NREG)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (bank_wr),
        .regs   (regs)
    );

    always_comb begin
        err_back      = regs.allow[REG_W-1 -: NIB_W];
        err_fwd       = regs.allow[NIB_W-1:0];
        blk_prot_back = {1'b0, regs.blk_prot[REG_W-1 -: NIB_W]} + 1'b1;
        blk_prot_fwd  = {1'b0, regs.blk_prot[NIB_W-1:0]} + 1'b1;
        frm_prot_back = {1'b0, regs.frm_prot[REG_W-1 -: NIB_W]} + 1'b1;
        frm_prot_fwd  = {1'b0, regs.frm_prot[NIB_W-1:0]} + 1'b1;
        corr_thresh   = NIB_W'(THR_BASE) + {1'b0, regs.thr};
        skip_block    = regs.blk_num;
    end

    // R5: the two ports never both request in one cycle
    a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_wr.vld && par_wr.vld));

    // R8: threshold stays within its mapped range
    a_r8_thresh_range: assert property (@(posedge clk) disable iff (!rst_n)
        corr_thresh >= NIB_W'(THR_BASE));

endmodule

// File: tb/crl_loader_test.sv
`timescale 1ns/1ps
module crl_loader_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_serial = 1'b0;
    logic       ser_clk = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
    logic [2:0] par_sel = '0;
    logic [7:0] par_data = '0;
    logic       par_stb_n = 1'b1;
    logic       par_dat_in, ser_rd_sel;
    logic [3:0] err_back, err_fwd, corr_thresh;
    logic [4:0] blk_prot_back, blk_prot_fwd, frm_prot_back, frm_prot_fwd;
    logic [7:0] skip_block;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m_allow, m_blk, m_frm, m_thr, m_num;

    always #2.5 clk = ~clk;

    crl_loader uut (
        .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial),
        .ser_clk(ser_clk), .ser_en(ser_en), .ser_din(ser_din),
        .par_sel(par_sel), .par_data(par_data), .par_stb_n(par_stb_n),
        .par_dat_in(par_dat_in), .ser_rd_sel(ser_rd_sel),
        .err_back(err_back), .err_fwd(err_fwd),
        .blk_prot_back(blk_prot_back), .blk_prot_fwd(blk_prot_fwd),
        .frm_prot_back(frm_prot_back), .frm_prot_fwd(frm_prot_fwd),
        .corr_thresh(corr_thresh), .skip_block(skip_block)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_defaults();
        m_allow = 8'h22; m_blk = 8'h17; m_frm = 8'h17; m_thr = 8'd7; m_num = 8'd0;
    endtask

    function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] nw);
        logic [7:0] r;
        r[7:4] = (nw[7:4] == 0) ? old[7:4] : nw[7:4];
        r[3:0] = (nw[3:0] == 0) ? old[3:0] : nw[3:0];
        return r;
    endfunction

    task automatic model_write(input int sel, input logic [7:0] d);
        case (sel)
            0: m_allow = d;
            1: m_blk = merge(m_blk, d);
            2: m_frm = merge(m_frm, d);
            3: m_thr = {5'd0, d[2:0]};
            4: if (d <= 8'd189) m_num = d;
            default: ;
        endcase
    endtask

    task automatic check_all(input string req);
        chk(req, "err_back", int'(err_back), int'(m_allow[7:4]));
        chk(req, "err_fwd", int'(err_fwd), int'(m_allow[3:0]));
        chk(req, "blk_back", int'(blk_prot_back), int'(m_blk[7:4]) + 1);
        chk(req, "blk_fwd", int'(blk_prot_fwd), int'(m_blk[3:0]) + 1);
        chk(req, "frm_back", int'(frm_prot_back), int'(m_frm[7:4]) + 1);
        chk(req, "frm_fwd", int'(frm_prot_fwd), int'(m_frm[3:0]) + 1);
        chk(req, "thresh", int'(corr_thresh), 8 + int'(m_thr));
        chk(req, "skip", int'(skip_block), int'(m_num));
    endtask

    task automatic par_write(input int sel, input logic [7:0] d);
        @(negedge clk);
        par_sel = 3'(sel); par_data = d; par_stb_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        par_stb_n = 1'b1;
        par_data = ~d;
        repeat (3) @(negedge clk);
    endtask

    task automatic ser_xfer(input logic [7:0] addr, input int nbits, input logic [15:0] word,
                            input logic chk_rd, input logic exp_rd, input string req);
        @(negedge clk);
        ser_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ser_din = addr[i]; ser_clk = 1'b0;
            @(negedge clk); ser_clk = 1'b1;
        end
        @(negedge clk); ser_clk = 1'b0;
        @(negedge clk); ser_en = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); ser_din = word[i % 16]; ser_clk = 1'b0;
            @(negedge clk); ser_clk = 1'b1;
            if (chk_rd && i == 4) chk(req, "ser_rd_sel", int'(ser_rd_sel), int'(exp_rd));
        end
        @(negedge clk); ser_clk = 1'b0;
        @(negedge clk); ser_en = 1'b0;
        repeat (3) @(negedge clk);
        if (chk_rd) chk(req, "ser_rd_sel idle", int'(ser_rd_sel), 0);
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk); mode_serial = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic reset_strobe(input bit raise_early);
        @(negedge clk);
        rst_n = 1'b0; mode_serial = 1'b0; par_stb_n = 1'b0;
        par_sel = 3'd0; par_data = 8'h55;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        if (raise_early) begin
            #1 par_stb_n = 1'b1;
        end else begin
            @(negedge clk); par_stb_n = 1'b1;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_defaults();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1");
        chk("R4", "dat_in idle", int'(par_dat_in), 0);

        // R4 direction while strobe low in parallel mode
        @(negedge clk); par_stb_n = 1'b0;
        @(negedge clk); chk("R4", "dat_in low strobe", int'(par_dat_in), 1);
        par_stb_n = 1'b1; par_sel = 3'd7;
        repeat (3) @(negedge clk);

        // R6..R9: parallel sweeps of every value into every register
        for (int s = 0; s < 5; s++) begin
            for (int v = 0; v < 256; v++) begin
                par_write(s, 8'(v));
                model_write(s, 8'(v));
                case (s)
                    0: check_all("R6");
                    1: check_all("R7");
                    2: check_all("R7");
                    3: check_all("R8");
                    default: check_all("R9");
                endcase
            end
        end

        // R10: out-of-range selects from the parallel port
        for (int s = 5; s < 8; s++) begin
            par_write(s, 8'h33);
            check_all("R10");
        end

        // R5: serial transfer ignored in parallel mode
        ser_xfer(8'hFA, 16, {4'h0, 4'd0, 8'h9C}, 1'b0, 1'b0, "R5");
        check_all("R5");

        // serial mode
        set_mode(1'b1);
        chk("R4", "dat_in serial mode", int'(par_dat_in), 0);
        @(negedge clk); par_stb_n = 1'b0;
        @(negedge clk); chk("R4", "dat_in serial low strobe", int'(par_dat_in), 0);
        par_stb_n = 1'b1;
        repeat (3) @(negedge clk);

        par_write(0, 8'h5A);
        check_all("R5");

        // R2: serial writes with garbage in bits 15..12
        for (int s = 0; s < 5; s++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] d;
                d = 8'(37 * k + 11 * s + 3);
                if (k == 3) d = 8'hC0;
                ser_xfer(8'hFA, 16, {4'(4'hA ^ 4'(k)), 4'(s), d}, 1'b1, 1'b0, "R2");
                model_write(s, d);
                check_all("R2");
            end
        end

        // R10: serial selects above 4
        for (int s = 5; s < 16; s++) begin
            ser_xfer(8'hFA, 16, {4'h0, 4'(s), 8'h44}, 1'b0, 1'b0, "R10");
            check_all("R10");
        end

        // R3: read address, wrong address, wrong bit counts
        ser_xfer(8'hFB, 16, {4'h0, 4'd0, 8'h11}, 1'b1, 1'b1, "R3");
        check_all("R3");
        ser_xfer(8'hEA, 16, {4'h0, 4'd0, 8'h12}, 1'b1, 1'b0, "R3");
        check_all("R3");
        ser_xfer(8'hFA, 15, {4'h0, 4'd0, 8'h13}, 1'b0, 1'b0, "R3");
        check_all("R3");
        ser_xfer(8'hFA, 17, {4'h0, 4'd0, 8'h14}, 1'b0, 1'b0, "R3");
        check_all("R3");
        ser_xfer(8'hFA, 16, {4'h0, 4'd0, 8'h15}, 1'b0, 1'b0, "R2");
        model_write(0, 8'h15);
        check_all("R2");

        // R11: strobe rising before the first edge after release is not an edge
        reset_strobe(1'b1);
        model_defaults();
        check_all("R11");
        reset_strobe(1'b0);
        model_defaults();
        model_write(0, 8'h55);
        check_all("R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule